// File: doc/BRIEF.md
# Inter-VM Doorbell Interrupt Registers

This block is the register front end of a shared-memory device that lets virtual machines signal one another. Software sees a 256-byte window of 32-bit registers: an interrupt enable mask, an interrupt cause register that clears when it is read, and a read-only register that reports the device's own peer number. A single level interrupt line is high whenever an enabled cause bit is set. The peer side can load an 8-bit event code straight into the cause register.

A write to the doorbell register names a destination peer and a vector. The block checks the request against a small table that holds, for each peer, how many vectors it has registered. The table is loaded through a configuration port. A request that passes the check comes out as a one-cycle notify pulse that carries the peer and the vector. A request that fails is dropped without any indication.

Register map by word offset: enable mask 0x00, cause 0x04, own position 0x08, doorbell 0x0C. Access size is encoded on `busSize` as 0 = byte, 1 = halfword, 2 = word. The value 3 counts as a narrow access.

Top module: `vmbell_regs`

## Requirements
- R1: After the asynchronous reset, the mask and the cause register read as 0, `irq` is low and `bellValid` is low.
- R2: `irq` is high exactly when the bitwise AND of the cause register and the mask is non-zero. It follows every change to either register in the cycle after that change.
- R3: A word write to offset 0x00 or 0x04 replaces all 32 bits of that register.
- R4: A word read of offset 0x04 returns the current cause value one cycle later on `busRdData` with `busRdValid`. The same edge clears the cause register, so `irq` is low in the following cycle unless an event arrives.
- R5: A word write to offset 0x0C takes the destination peer from bits 31:16 and the vector from bits 7:0, and ignores bits 15:8. If the request is accepted, `bellValid` is high for exactly the next cycle, with `bellPeer` and `bellVector` set to those fields.
- R6: A doorbell is dropped with no pulse in either of two cases: the destination is above the highest registered peer, or the vector is not below that peer's registered vector count.
- R7: A word read of offset 0x08 returns the zero-extended `selfId` when `mapped` is high, and 0xFFFFFFFF when it is low.
- R8: Byte and halfword accesses have no effect. Narrow writes change nothing. Narrow reads return 0 with `busRdValid` and do not clear the cause register.
- R9: Write decoding uses only address bits 7:2, so 0x02 writes the mask. A read decodes a register only at its exact aligned offset and returns 0 at any other offset. Writes to 0x08 or to undefined offsets do nothing. A cycle that has both enables set performs only the write.
- R10: When `evtValid` is high, `evtData` is loaded zero-extended into the cause register. This takes priority over a same-cycle bus write to the cause register, a cause read-clear and `softRst`.
- R11: `softRst` clears the cause register and leaves the mask unchanged.
- R12: A `cfgWrEn` pulse stores `cfgCount` as the vector count of peer `cfgPeer`. The highest registered peer is the largest peer ever written with a non-zero count, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Device reset; clears the cause register only |
| busAddr | input | 8 | Byte address inside the register window |
| busSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, registered |
| busRdValid | output | 1 | High the cycle after a read strobe |
| evtValid | input | 1 | Event from a peer |
| evtData | input | 8 | Event code loaded into the cause register |
| mapped | input | 1 | Shared region is mapped |
| selfId | input | 16 | Own peer number |
| cfgWrEn | input | 1 | Vector-count table write |
| cfgPeer | input | IDX_W | Peer index for the table write |
| cfgCount | input | CNT_W | Vector count for that peer |
| irq | output | 1 | Level interrupt |
| bellValid | output | 1 | Accepted doorbell pulse |
| bellPeer | output | 16 | Destination peer of the pulse |
| bellVector | output | 8 | Vector of the pulse |

## Verification
The assertions check the cycle-level rules on every cycle:
- a cause read with no competing event always lowers `irq`;
- a device reset does the same when nothing reloads the cause register;
- narrow writes never move `irq`, and narrow reads always return zero;
- an unmapped position read gives all ones;
- each doorbell pulse is traced back to a word doorbell write one cycle earlier.

Some properties can only be shown by the bench's scenarios, because they depend on the contents of the table and on data values:
- whether a doorbell is accepted or dropped for a given table content;
- the exact read-back values after full-width writes;
- which value wins when an event collides with a read or a write;
- that a device reset keeps the mask.

// File: rtl/vmbell_pkg.sv
package vmbell_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // word indices inside the window (address bits 7:2)
  localparam logic [5:0] IDX_MASK   = 6'd0;
  localparam logic [5:0] IDX_CAUSE  = 6'd1;
  localparam logic [5:0] IDX_POS    = 6'd2;
  localparam logic [5:0] IDX_BELL   = 6'd3;

  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_MASK  = 2'd1,
    RSEL_CAUSE = 2'd2,
    RSEL_POS   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrCause;
    logic   rdCause;
    logic   wrBell;
    logic   rdFire;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/vmbell_ctrl.sv
module vmbell_ctrl
  import vmbell_pkg::*;
(
  input  logic [7:0]  busAddr,
  input  logic [1:0]  busSize,
  input  logic        busWrEn,
  input  logic        busRdEn,
  output ctrlStrobe_t strb
);

  logic       wordAcc;
  logic [5:0] wordIdx;
  logic       aligned;

  assign wordAcc = (busSize == SZ_WORD);
  assign wordIdx = busAddr[7:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strb = '0;
    strb.rdSel = RSEL_NONE;
    if (busWrEn) begin
      if (wordAcc) begin
        unique case (wordIdx)
          IDX_MASK:  strb.wrMask  = 1'b1;
          IDX_CAUSE: strb.wrCause = 1'b1;
          IDX_BELL:  strb.wrBell  = 1'b1;
          default:   ;
        endcase
      end
    end else if (busRdEn) begin
      strb.rdFire = 1'b1;
      if (wordAcc && aligned) begin
        unique case (wordIdx)
          IDX_MASK:  strb.rdSel = RSEL_MASK;
          IDX_CAUSE: begin
            strb.rdSel   = RSEL_CAUSE;
            strb.rdCause = 1'b1;
          end
          IDX_POS:   strb.rdSel = RSEL_POS;
          default:   strb.rdSel = RSEL_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/vmbell_dpath.sv
module vmbell_dpath
  import vmbell_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int CNT_W     = 8,
  parameter int PEER_W    = 16,
  parameter int VEC_W     = 8,
  localparam int IDX_W    = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  ctrlStrobe_t       strb,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              busRdValid,
  input  logic              evtValid,
  input  logic [7:0]        evtData,
  input  logic              mapped,
  input  logic [PEER_W-1:0] selfId,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgPeer,
  input  logic [CNT_W-1:0]  cfgCount,
  output logic              irq,
  output logic              bellValid,
  output logic [PEER_W-1:0] bellPeer,
  output logic [VEC_W-1:0]  bellVector
);

  logic [31:0] maskReg;
  logic [31:0] causeReg;
  logic [IDX_W-1:0] maxPeer;
  logic [CNT_W-1:0] vecCount [NUM_PEERS];

  // ---------------- peer vector-count table ----------------
  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_peer
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vecCount[p] <= '0;
      end else if (cfgWrEn && (cfgPeer == IDX_W'(p))) begin
        vecCount[p] <= cfgCount;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxPeer <= '0;
    end else if (cfgWrEn && (cfgCount != '0) && (cfgPeer > maxPeer)) begin
      maxPeer <= cfgPeer;
    end
  end

  // ---------------- mask and cause ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
    end else if (strb.wrMask) begin
      maskReg <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg <= '0;
    end else if (evtValid) begin
      causeReg <= {24'd0, evtData};
    end else if (strb.wrCause) begin
      causeReg <= busWrData;
    end else if (strb.rdCause || softRst) begin
      causeReg <= '0;
    end
  end

  assign irq = |(causeReg & maskReg);

  // ---------------- read path ----------------
  logic [31:0] posValue;
  logic [31:0] rdMux;

  assign posValue = mapped ? {{(32-PEER_W){1'b0}}, selfId} : 32'hFFFF_FFFF;

  always_comb begin
    unique case (strb.rdSel)
      RSEL_MASK:  rdMux = maskReg;
      RSEL_CAUSE: rdMux = causeReg;
      RSEL_POS:   rdMux = posValue;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdValid <= 1'b0;
      busRdData  <= '0;
    end else begin
      busRdValid <= strb.rdFire;
      if (strb.rdFire) begin
        busRdData <= rdMux;
      end
    end
  end

  // ---------------- doorbell validation ----------------
  logic [PEER_W-1:0] reqPeer;
  logic [VEC_W-1:0]  reqVec;
  logic [IDX_W-1:0]  reqIdx;
  logic              peerOk;
  logic              vecOk;
  logic              bellAccept;

  assign reqPeer = busWrData[31:16];
  assign reqVec  = busWrData[VEC_W-1:0];
  assign reqIdx  = reqPeer[IDX_W-1:0];
  assign peerOk  = (reqPeer <= PEER_W'(maxPeer));
  assign vecOk   = (int'(reqVec) < int'(vecCount[reqIdx]));
  assign bellAccept = strb.wrBell && peerOk && vecOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bellValid  <= 1'b0;
      bellPeer   <= '0;
      bellVector <= '0;
    end else begin
      bellValid <= bellAccept;
      if (bellAccept) begin
        bellPeer   <= reqPeer;
        bellVector <= reqVec;
      end
    end
  end

endmodule

// File: rtl/vmbell_regs.sv
module vmbell_regs
  import vmbell_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic [7:0]       busAddr,
  input  logic [1:0]       busSize,
  input  logic             busWrEn,
  input  logic [31:0]      busWrData,
  input  logic             busRdEn,
  output logic [31:0]      busRdData,
  output logic             busRdValid,
  input  logic             evtValid,
  input  logic [7:0]       evtData,
  input  logic             mapped,
  input  logic [15:0]      selfId,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgPeer,
  input  logic [CNT_W-1:0] cfgCount,
  output logic             irq,
  output logic             bellValid,
  output logic [15:0]      bellPeer,
  output logic [7:0]       bellVector
);

  ctrlStrobe_t strb;

  vmbell_ctrl u_ctrl (
    .busAddr (busAddr),
    .busSize (busSize),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  vmbell_dpath #(
    .NUM_PEERS (NUM_PEERS),
    .CNT_W     (CNT_W),
    .PEER_W    (16),
    .VEC_W     (8)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .softRst    (softRst),
    .strb       (strb),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .busRdValid (busRdValid),
    .evtValid   (evtValid),
    .evtData    (evtData),
    .mapped     (mapped),
    .selfId     (selfId),
    .cfgWrEn    (cfgWrEn),
    .cfgPeer    (cfgPeer),
    .cfgCount   (cfgCount),
    .irq        (irq),
    .bellValid  (bellValid),
    .bellPeer   (bellPeer),
    .bellVector (bellVector)
  );

endmodule

// File: rtl/vmbell_chk.sv
module vmbell_chk (
  input logic        clk,
  input logic        rstN,
  input logic        softRst,
  input logic [7:0]  busAddr,
  input logic [1:0]  busSize,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic [31:0] busRdData,
  input logic        busRdValid,
  input logic        evtValid,
  input logic        mapped,
  input logic        irq,
  input logic        bellValid
);

  logic wordWr;
  logic wordRd;
  assign wordWr = busWrEn && (busSize == 2'd2);
  assign wordRd = busRdEn && !busWrEn && (busSize == 2'd2);

  // R4: reading the cause register drops the interrupt
  a_r4_read_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    (wordRd && busAddr == 8'h04 && !evtValid) |=> !irq);

  // R11: device reset drops the interrupt when nothing reloads the cause
  a_r11_softrst_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    (softRst && !evtValid && !(wordWr && busAddr[7:2] == 6'd1)) |=> !irq);

  // R8: narrow writes leave the interrupt unchanged
  a_r8_narrow_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busSize != 2'd2 && !evtValid && !softRst) |=> $stable(irq));

  // R8: narrow reads return zero
  a_r8_narrow_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && busSize != 2'd2) |=> (busRdValid && busRdData == 32'd0));

  // R7: position reads all ones while unmapped
  a_r7_unmapped_pos: assert property (@(posedge clk) disable iff (!rstN)
    (wordRd && busAddr == 8'h08 && !mapped) |=> (busRdData == 32'hFFFF_FFFF));

  // R5: every doorbell pulse comes from a word doorbell write one cycle earlier
  a_r5_bell_source: assert property (@(posedge clk) disable iff (!rstN)
    bellValid |-> $past(wordWr && busAddr[7:2] == 6'd3));

endmodule

bind vmbell_regs vmbell_chk u_chk (.*);

// File: tb/test_vmbell_regs.sv
module test_vmbell_regs;

  localparam logic [1:0] B = 2'd0, H = 2'd1, W = 2'd2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic        evtValid = 1'b0;
  logic [7:0]  evtData = '0;
  logic        mapped = 1'b0;
  logic [15:0] selfId = '0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgPeer = '0;
  logic [7:0]  cfgCount = '0;
  logic        irq;
  logic        bellValid;
  logic [15:0] bellPeer;
  logic [7:0]  bellVector;

  int checks = 0;
  int errors = 0;

  logic [31:0] rdQ[$];
  string       rdTagQ[$];
  logic [23:0] bellQ[$];

  always #2.5 clk = ~clk;

  vmbell_regs i_vmbell_regs (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitors
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (rdQ.size() == 0) chk(1'b0, "read without request", busRdData, 32'd0);
      else begin
        logic [31:0] e;
        string t;
        e = rdQ.pop_front();
        t = rdTagQ.pop_front();
        chk(busRdData === e, t, busRdData, e);
      end
    end
    if (rstN && bellValid) begin
      if (bellQ.size() == 0) chk(1'b0, "R6 unexpected doorbell", {8'd0, bellPeer, bellVector}, 32'd0);
      else begin
        logic [23:0] e;
        e = bellQ.pop_front();
        chk({bellPeer, bellVector} === e, "R5 doorbell fields", {8'd0, bellPeer, bellVector}, {8'd0, e});
      end
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busSize = sz; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] e, input string tag);
    @(negedge clk);
    rdQ.push_back(e); rdTagQ.push_back(tag);
    busAddr = a; busSize = sz; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic sendEvt(input logic [7:0] v);
    @(negedge clk);
    evtValid = 1'b1; evtData = v;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] p, input logic [7:0] c);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgPeer = p; cfgCount = c;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic ring(input logic [15:0] peer, input logic [7:0] mid, input logic [7:0] vec,
                      input logic [1:0] sz, input bit accept);
    if (accept) bellQ.push_back({peer, vec});
    busWrite(8'h0C, sz, {peer, mid, vec});
  endtask

  task automatic chkIrq(input logic e, input string tag);
    chk(irq === e, tag, {31'd0, irq}, {31'd0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkIrq(1'b0, "R1 irq after reset");
    chk(bellValid === 1'b0, "R1 bellValid after reset", {31'd0, bellValid}, 32'd0);
    busRead(8'h00, W, 32'd0, "R1 mask after reset");
    busRead(8'h04, W, 32'd0, "R1 cause after reset");

    // R12 table load
    cfg(4'd0, 8'd2);
    cfg(4'd3, 8'd4);
    cfg(4'd1, 8'd0);

    // R3 / R2
    busWrite(8'h00, W, 32'hA5A5_0F0F);
    busRead(8'h00, W, 32'hA5A5_0F0F, "R3 mask full write");
    busWrite(8'h04, W, 32'h0000_0100);
    chkIrq(1'b1, "R2 enabled cause raises irq");
    busWrite(8'h00, W, 32'h0000_00FF);
    chkIrq(1'b0, "R2 masked cause lowers irq");
    busRead(8'h04, W, 32'h0000_0100, "R3 cause full write");

    // R4 read clears
    busWrite(8'h04, W, 32'h0000_0012);
    chkIrq(1'b1, "R2 irq from cause 0x12");
    busRead(8'h04, W, 32'h0000_0012, "R4 cause read value");
    chkIrq(1'b0, "R4 irq after cause read");
    busRead(8'h04, W, 32'd0, "R4 cause cleared");

    // R7 position
    mapped = 1'b0; selfId = 16'd5;
    busRead(8'h08, W, 32'hFFFF_FFFF, "R7 unmapped position");
    mapped = 1'b1;
    busRead(8'h08, W, 32'd5, "R7 mapped position");

    // R8 narrow accesses
    busWrite(8'h00, B, 32'd0);
    busRead(8'h00, W, 32'h0000_00FF, "R8 byte write ignored");
    busRead(8'h00, H, 32'd0, "R8 halfword read zero");
    busWrite(8'h04, W, 32'd3);
    busRead(8'h04, H, 32'd0, "R8 narrow cause read zero");
    busRead(8'h04, W, 32'd3, "R8 narrow read did not clear");

    // R9 decode
    busWrite(8'h02, W, 32'h0000_000F);
    busRead(8'h00, W, 32'h0000_000F, "R9 masked write address");
    busWrite(8'h08, W, 32'h0);
    busRead(8'h08, W, 32'd5, "R9 position write ignored");
    busWrite(8'h40, W, 32'h0);
    busRead(8'h00, W, 32'h0000_000F, "R9 undefined write ignored");
    busRead(8'h20, W, 32'd0, "R9 undefined read zero");
    busRead(8'h01, W, 32'd0, "R9 unaligned read zero");

    // R10 events
    sendEvt(8'h81);
    chkIrq(1'b1, "R10 event raises irq");
    busRead(8'h04, W, 32'h0000_0081, "R10 event value");
    busWrite(8'h04, W, 32'h0000_0044);
    @(negedge clk);
    rdQ.push_back(32'h44); rdTagQ.push_back("R10 read during event");
    busAddr = 8'h04; busSize = W; busRdEn = 1'b1; evtValid = 1'b1; evtData = 8'h09;
    @(negedge clk);
    busRdEn = 1'b0; evtValid = 1'b0;
    busRead(8'h04, W, 32'h0000_0009, "R10 event wins over read clear");
    @(negedge clk);
    busAddr = 8'h04; busSize = W; busWrData = 32'h0000_FFFF; busWrEn = 1'b1;
    evtValid = 1'b1; evtData = 8'h02;
    @(negedge clk);
    busWrEn = 1'b0; evtValid = 1'b0;
    busRead(8'h04, W, 32'h0000_0002, "R10 event wins over write");
    sendEvt(8'hF0);
    chkIrq(1'b0, "R10 masked event no irq");
    busRead(8'h04, W, 32'h0000_00F0, "R10 zero extension");

    // R11 device reset
    busWrite(8'h04, W, 32'd3);
    chkIrq(1'b1, "R11 irq before device reset");
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    chkIrq(1'b0, "R11 irq after device reset");
    busRead(8'h00, W, 32'h0000_000F, "R11 mask kept");
    busRead(8'h04, W, 32'd0, "R11 cause cleared");

    // R5 / R6 doorbells
    ring(16'd0, 8'h00, 8'd1, W, 1'b1);
    @(negedge clk);
    chk(bellValid === 1'b0, "R5 pulse single cycle", {31'd0, bellValid}, 32'd0);
    ring(16'd3, 8'hAB, 8'd3, W, 1'b1);
    ring(16'd3, 8'h00, 8'd4, W, 1'b0);
    ring(16'd4, 8'h00, 8'd0, W, 1'b0);
    ring(16'd1, 8'h00, 8'd0, W, 1'b0);
    ring(16'h0100, 8'h00, 8'd0, W, 1'b0);
    ring(16'd0, 8'h00, 8'd2, W, 1'b0);
    ring(16'd0, 8'h00, 8'd0, H, 1'b0);
    // R12 raising the highest peer
    cfg(4'd5, 8'd1);
    ring(16'd5, 8'h00, 8'd0, W, 1'b1);
    cfg(4'd2, 8'hFF);
    ring(16'd2, 8'h00, 8'hFE, W, 1'b1);
    ring(16'd2, 8'h00, 8'hFF, W, 1'b0);

    repeat (4) @(negedge clk);
    chk(bellQ.size() == 0, "R5 all accepted doorbells seen", bellQ.size(), 32'd0);
    chk(rdQ.size() == 0, "R4 all reads answered", rdQ.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule